// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block predicts the direction of conditional branches by running two direction predictors side by side and choosing between them per branch. The first component keeps a short outcome history for each branch address and uses that history to pick a saturating counter. The second component XORs a single global outcome history with PC bits to pick a counter in a larger table. A third table of 4-state selector counters, indexed by PC bits, decides which of the two guesses becomes the final prediction.

The fetch side is purely combinational. It takes a PC and returns the final guess, both component guesses, the selector decision and the three table indices it used. The pipeline carries these values along with the branch. When the branch resolves, it presents them again on the resolve port together with the real outcome, and all three structures are trained at the carried indices in one clock edge. The global history is shifted only at resolution. No history repair and no target prediction are done here.

Top module: `tourney_bp`

## Requirements
- R1: After reset every counter in both component tables holds 1 (weakly not taken), every selector entry holds 1 (weakly favours the local component), and all local histories and the global history are zero. A fetch right after reset therefore reports not taken from both components and as the final guess, selector output 0, and local index 0.
- R2: `fetch_use_global` is 1 when the addressed selector entry is 2 or 3, and 0 when it is 0 or 1. `fetch_taken` equals `fetch_global_taken` when `fetch_use_global` is 1, and `fetch_local_taken` otherwise.
- R3: The local history register is chosen by PC bits [7:2]. Its 6-bit value is `fetch_local_idx` and selects the local counter. On resolve, the register chosen by `rslv_pc[7:2]` shifts left, and the outcome enters bit 0.
- R4: All component counters are 2-bit saturating counters. A counter predicts taken when its value is 2 or 3. A taken outcome adds 1 and stops at 3. A not-taken outcome subtracts 1 and stops at 0.
- R5: On resolve, the selector entry at `rslv_chooser_idx` steps down by 1 toward the local side (stopping at 0) when only the local guess matched the outcome. It steps up by 1 toward the global side (stopping at 3) when only the global guess matched. It stays unchanged when both guesses matched or both missed.
- R6: From a strong selector state (0 or 3), one disagreement favouring the other component leaves the selection unchanged. A second such disagreement switches it.
- R7: The global history is 8 bits, cleared at reset, and shifted left with the outcome in bit 0 on every resolve. `fetch_global_idx` equals `fetch_pc[9:2]` XOR the global history.
- R8: `fetch_chooser_idx` equals `fetch_pc[9:2]`. Training writes the local counter, the global counter and the selector at the carried `rslv_local_idx`, `rslv_global_idx` and `rslv_chooser_idx`, not at indices recomputed from `rslv_pc`.
- R9: Both counter tables and the local history are trained on every resolve, whichever component was selected. A cycle with `rslv_valid` low changes no state, whatever the other resolve inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | PC being predicted |
| fetch_taken | output | 1 | Final direction guess |
| fetch_local_taken | output | 1 | Local component guess |
| fetch_global_taken | output | 1 | Global component guess |
| fetch_use_global | output | 1 | Selector picked the global component |
| fetch_local_idx | output | 6 | Local counter index (history value) |
| fetch_global_idx | output | 8 | Global counter index |
| fetch_chooser_idx | output | 8 | Selector index |
| rslv_valid | input | 1 | A branch resolves this cycle |
| rslv_pc | input | 32 | PC of the resolving branch |
| rslv_taken | input | 1 | Actual outcome |
| rslv_local_taken | input | 1 | Local guess carried from fetch |
| rslv_global_taken | input | 1 | Global guess carried from fetch |
| rslv_local_idx | input | 6 | Local counter index carried from fetch |
| rslv_global_idx | input | 8 | Global counter index carried from fetch |
| rslv_chooser_idx | input | 8 | Selector index carried from fetch |

## Verification
The hardest case to reach is a selector entry walked through strong and weak states. This needs a run of resolves in which exactly one component is right, and from real branch streams both components tend to learn the same pattern and agree. The bench reaches it directly, because the carried component guesses are inputs: directed resolves claim a chosen local/global guess pair against a chosen outcome at one selector index. A fetch of that PC after each step shows the selection flip only on the second opposing step. Seeded random streams over a small PC pool then mix aliasing, saturation and history effects.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

   // Selector states, ordered so that stepping up moves toward the global side
   typedef enum logic [1:0] {
      SEL_STRONG_LOC = 2'd0,
      SEL_WEAK_LOC   = 2'd1,
      SEL_WEAK_GLB   = 2'd2,
      SEL_STRONG_GLB = 2'd3
   } sel_state_e;

   typedef struct packed {
      logic step;   // selector entry moves this resolve
      logic up;     // move toward the global side
   } sel_train_t;

   function automatic sel_train_t sel_train(input logic loc_ok, input logic glb_ok);
      sel_train_t r;
      r.step = loc_ok ^ glb_ok;
      r.up   = glb_ok;
      return r;
   endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
   parameter int ENTRIES = 256,
   parameter int CTR_W   = 2,
   parameter int INIT    = 1,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CTR_W-1:0] rd_val,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up
);

   localparam logic [CTR_W-1:0] MAX_V  = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] INIT_V = CTR_W'(INIT);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_depth
      $error("tbp_ctr_table: ENTRIES must be a power of two");
   end
   if (CTR_W < 1 || INIT > (1 << CTR_W) - 1) begin : g_bad_init
      $error("tbp_ctr_table: INIT out of counter range");
   end

   logic [CTR_W-1:0] mem [ENTRIES];
   logic [CTR_W-1:0] cur;
   logic [CTR_W-1:0] nxt;

   assign rd_val = mem[rd_idx];
   assign cur    = mem[wr_idx];

   always_comb begin
      nxt = cur;
      if (wr_up && cur != MAX_V)      nxt = cur + 1'b1;
      else if (!wr_up && cur != '0)   nxt = cur - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) mem[i] <= INIT_V;
      end else if (wr_en) begin
         mem[wr_idx] <= nxt;
      end
   end

   // checker capture of the previous write
   logic             chk_en;
   logic             chk_up;
   logic [IDX_W-1:0] chk_idx;
   logic [CTR_W-1:0] chk_old;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_en  <= 1'b0;
         chk_up  <= 1'b0;
         chk_idx <= '0;
         chk_old <= '0;
      end else begin
         chk_en  <= wr_en;
         chk_up  <= wr_up;
         chk_idx <= wr_idx;
         chk_old <= cur;
      end
   end

   // R4: a saturated entry stays at its end value
   p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && chk_up && chk_old == MAX_V) |-> mem[chk_idx] == MAX_V);
   p_sat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !chk_up && chk_old == '0) |-> mem[chk_idx] == '0);
   // R6: a written entry moves by exactly one step unless saturated
   p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && chk_up && chk_old != MAX_V) |-> mem[chk_idx] == chk_old + 1'b1);

endmodule

// File: rtl/tbp_local_hist.sv
module tbp_local_hist #(
   parameter int ENTRIES = 64,
   parameter int HIST_W  = 6,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_taken
);

   if ((1 << IDX_W) != ENTRIES) begin : g_bad_depth
      $error("tbp_local_hist: ENTRIES must be a power of two");
   end
   if (HIST_W < 1) begin : g_bad_width
      $error("tbp_local_hist: HIST_W must be positive");
   end

   logic [HIST_W-1:0] hist [ENTRIES];
   logic [HIST_W-1:0] shifted;

   assign rd_hist = hist[rd_idx];

   if (HIST_W == 1) begin : g_one
      assign shifted = wr_taken;
   end else begin : g_multi
      assign shifted = {hist[wr_idx][HIST_W-2:0], wr_taken};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) hist[i] <= '0;
      end else if (wr_en) begin
         hist[wr_idx] <= shifted;
      end
   end

   logic             chk_en;
   logic             chk_t;
   logic [IDX_W-1:0] chk_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_en  <= 1'b0;
         chk_t   <= 1'b0;
         chk_idx <= '0;
      end else begin
         chk_en  <= wr_en;
         chk_t   <= wr_taken;
         chk_idx <= wr_idx;
      end
   end

   // R3: the newest outcome lands in bit 0 of the written history
   p_newest_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> hist[chk_idx][0] == chk_t);

endmodule

// File: rtl/tbp_global_hist.sv
module tbp_global_hist #(
   parameter int HIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic              taken,
   output logic [HIST_W-1:0] hist
);

   if (HIST_W < 2) begin : g_bad_width
      $error("tbp_global_hist: HIST_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   hist <= '0;
      else if (upd) hist <= {hist[HIST_W-2:0], taken};
   end

   // R7: shift with the outcome entering at bit 0
   p_shift_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> hist[0] == $past(taken) && hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]));
   // R9: no resolve, no history change
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> $stable(hist));

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
   parameter int PC_W       = 32,
   parameter int ALIGN      = 2,
   parameter int LH_ENTRIES = 64,
   parameter int LH_W       = 6,
   parameter int GH_W       = 8,
   parameter int CH_ENTRIES = 256,
   parameter int CTR_W      = 2,
   parameter bit GLB_XOR    = 1'b1,
   localparam int LH_IDX_W  = $clog2(LH_ENTRIES),
   localparam int CH_IDX_W  = $clog2(CH_ENTRIES),
   localparam int CTR_INIT  = (1 << (CTR_W - 1)) - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PC_W-1:0]     fetch_pc,
   output logic                fetch_taken,
   output logic                fetch_local_taken,
   output logic                fetch_global_taken,
   output logic                fetch_use_global,
   output logic [LH_W-1:0]     fetch_local_idx,
   output logic [GH_W-1:0]     fetch_global_idx,
   output logic [CH_IDX_W-1:0] fetch_chooser_idx,
   input  logic                rslv_valid,
   input  logic [PC_W-1:0]     rslv_pc,
   input  logic                rslv_taken,
   input  logic                rslv_local_taken,
   input  logic                rslv_global_taken,
   input  logic [LH_W-1:0]     rslv_local_idx,
   input  logic [GH_W-1:0]     rslv_global_idx,
   input  logic [CH_IDX_W-1:0] rslv_chooser_idx
);
   import tbp_pkg::*;

   if (ALIGN + GH_W > PC_W || ALIGN + CH_IDX_W > PC_W || ALIGN + LH_IDX_W > PC_W) begin : g_bad_pc
      $error("tourney_bp: index slices exceed PC width");
   end
   if (CTR_W < 2) begin : g_bad_ctr
      $error("tourney_bp: CTR_W must be at least 2");
   end

   logic [GH_W-1:0]  ghist;
   logic [CTR_W-1:0] loc_ctr;
   logic [CTR_W-1:0] glb_ctr;
   logic [1:0]       sel_q;
   sel_train_t       sel_tr;

   logic unused_pc;
   assign unused_pc = ^{fetch_pc, rslv_pc};

   // ---------------- local component ----------------
   tbp_local_hist #(.ENTRIES(LH_ENTRIES), .HIST_W(LH_W)) u_lhist (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(fetch_pc[ALIGN +: LH_IDX_W]), .rd_hist(fetch_local_idx),
      .wr_en(rslv_valid), .wr_idx(rslv_pc[ALIGN +: LH_IDX_W]), .wr_taken(rslv_taken));

   tbp_ctr_table #(.ENTRIES(1 << LH_W), .CTR_W(CTR_W), .INIT(CTR_INIT)) u_lpht (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(fetch_local_idx), .rd_val(loc_ctr),
      .wr_en(rslv_valid), .wr_idx(rslv_local_idx), .wr_up(rslv_taken));

   // ---------------- global component ----------------
   tbp_global_hist #(.HIST_W(GH_W)) u_ghist (
      .clk(clk), .rst_n(rst_n), .upd(rslv_valid), .taken(rslv_taken), .hist(ghist));

   if (GLB_XOR) begin : g_xor_idx
      assign fetch_global_idx = fetch_pc[ALIGN +: GH_W] ^ ghist;
   end else begin : g_hist_idx
      assign fetch_global_idx = ghist;
   end

   tbp_ctr_table #(.ENTRIES(1 << GH_W), .CTR_W(CTR_W), .INIT(CTR_INIT)) u_gpht (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(fetch_global_idx), .rd_val(glb_ctr),
      .wr_en(rslv_valid), .wr_idx(rslv_global_idx), .wr_up(rslv_taken));

   // ---------------- selector ----------------
   assign fetch_chooser_idx = fetch_pc[ALIGN +: CH_IDX_W];
   assign sel_tr = sel_train(rslv_local_taken == rslv_taken,
                             rslv_global_taken == rslv_taken);

   tbp_ctr_table #(.ENTRIES(CH_ENTRIES), .CTR_W(2), .INIT(int'(SEL_WEAK_LOC))) u_sel (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(fetch_chooser_idx), .rd_val(sel_q),
      .wr_en(rslv_valid && sel_tr.step), .wr_idx(rslv_chooser_idx), .wr_up(sel_tr.up));

   // ---------------- outputs ----------------
   assign fetch_local_taken  = loc_ctr[CTR_W-1];
   assign fetch_global_taken = glb_ctr[CTR_W-1];
   assign fetch_use_global   = sel_q[1];
   assign fetch_taken        = fetch_use_global ? fetch_global_taken : fetch_local_taken;

   // R5: an agreeing resolve leaves the selection seen at that index unchanged
   p_agree_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rslv_valid && rslv_local_taken == rslv_global_taken && fetch_chooser_idx == rslv_chooser_idx
       && $stable(fetch_pc)) |=> ($stable(fetch_pc) -> $stable(fetch_use_global)));

endmodule

// File: tb/tourney_bp_bench.sv
`timescale 1ns/1ps
module tourney_bp_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        fetch_taken, fetch_local_taken, fetch_global_taken, fetch_use_global;
   logic [5:0]  fetch_local_idx;
   logic [7:0]  fetch_global_idx, fetch_chooser_idx;
   logic        rslv_valid = 1'b0, rslv_taken = 1'b0, rslv_local_taken = 1'b0, rslv_global_taken = 1'b0;
   logic [31:0] rslv_pc = '0;
   logic [5:0]  rslv_local_idx = '0;
   logic [7:0]  rslv_global_idx = '0, rslv_chooser_idx = '0;

   always #2 clk = ~clk;

   tourney_bp u_tourney_bp (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .fetch_taken(fetch_taken), .fetch_local_taken(fetch_local_taken),
      .fetch_global_taken(fetch_global_taken), .fetch_use_global(fetch_use_global),
      .fetch_local_idx(fetch_local_idx), .fetch_global_idx(fetch_global_idx),
      .fetch_chooser_idx(fetch_chooser_idx),
      .rslv_valid(rslv_valid), .rslv_pc(rslv_pc), .rslv_taken(rslv_taken),
      .rslv_local_taken(rslv_local_taken), .rslv_global_taken(rslv_global_taken),
      .rslv_local_idx(rslv_local_idx), .rslv_global_idx(rslv_global_idx),
      .rslv_chooser_idx(rslv_chooser_idx));

   int checks = 0;
   int errors = 0;

   // reference state built from the requirements
   logic [5:0] m_lh  [64];
   logic [1:0] m_lc  [64];
   logic [1:0] m_gc  [256];
   logic [1:0] m_sel [256];
   logic [7:0] m_gh;

   // expected fetch values of the last fetch
   logic [5:0] e_li;
   logic [7:0] e_gi, e_ci;
   logic       e_lp, e_gp, e_ug, e_t;

   function automatic logic [1:0] sat(input logic [1:0] v, input logic up);
      if (up)  return (v == 2'd3) ? v : v + 2'd1;
      return (v == 2'd0) ? v : v - 2'd1;
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 64; i++) begin m_lh[i] = '0; m_lc[i] = 2'd1; end
      for (int i = 0; i < 256; i++) begin m_gc[i] = 2'd1; m_sel[i] = 2'd1; end
      m_gh = '0;
   endtask

   task automatic model_resolve(input logic [31:0] pc, input logic [5:0] li, input logic [7:0] gi,
                                input logic [7:0] ci, input logic lp, input logic gp, input logic t);
      m_lc[li] = sat(m_lc[li], t);                      // R9 trained regardless of selection
      m_gc[gi] = sat(m_gc[gi], t);
      if (lp == t && gp != t) m_sel[ci] = sat(m_sel[ci], 1'b0);   // R5
      else if (gp == t && lp != t) m_sel[ci] = sat(m_sel[ci], 1'b1);
      m_lh[pc[7:2]] = {m_lh[pc[7:2]][4:0], t};         // R3
      m_gh = {m_gh[6:0], t};                            // R7
   endtask

   // drive a PC at the falling edge and compare all fetch outputs
   task automatic fetch_check(input logic [31:0] pc);
      @(negedge clk);
      fetch_pc = pc;
      #1;
      e_li = m_lh[pc[7:2]];
      e_lp = m_lc[e_li][1];
      e_gi = pc[9:2] ^ m_gh;
      e_gp = m_gc[e_gi][1];
      e_ci = pc[9:2];
      e_ug = m_sel[e_ci][1];
      e_t  = e_ug ? e_gp : e_lp;
      chk(fetch_local_idx == e_li, "R3 local index", fetch_local_idx, e_li);
      chk(fetch_local_taken == e_lp, "R4 local guess", fetch_local_taken, e_lp);
      chk(fetch_global_idx == e_gi, "R7 global index", fetch_global_idx, e_gi);
      chk(fetch_global_taken == e_gp, "R4 global guess", fetch_global_taken, e_gp);
      chk(fetch_chooser_idx == e_ci, "R8 selector index", fetch_chooser_idx, e_ci);
      chk(fetch_use_global == e_ug, "R5 selection", fetch_use_global, e_ug);
      chk(fetch_taken == e_t, "R2 final guess", fetch_taken, e_t);
   endtask

   // present one resolve during the next rising edge
   task automatic resolve(input logic [31:0] pc, input logic [5:0] li, input logic [7:0] gi,
                          input logic [7:0] ci, input logic lp, input logic gp, input logic t);
      @(negedge clk);
      rslv_valid = 1'b1; rslv_pc = pc; rslv_local_idx = li; rslv_global_idx = gi;
      rslv_chooser_idx = ci; rslv_local_taken = lp; rslv_global_taken = gp; rslv_taken = t;
      @(posedge clk);
      #1;
      rslv_valid = 1'b0;
      model_resolve(pc, li, gi, ci, lp, gp, t);
   endtask

   task automatic fetch_and_resolve(input logic [31:0] pc, input logic t);
      fetch_check(pc);
      resolve(pc, e_li, e_gi, e_ci, e_lp, e_gp, t);
   endtask

   logic done = 1'b0;

   initial begin
      #800000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      logic [31:0] pool [16];
      seed = 32'd1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state seen through fetches
      fetch_check(32'h0000_0040);
      chk(fetch_taken == 1'b0 && fetch_use_global == 1'b0 && fetch_local_idx == 6'd0,
          "R1 reset fetch", {fetch_taken, fetch_use_global, fetch_local_idx}, 0);
      fetch_check(32'hFFFF_FFFC);
      fetch_check(32'h1234_5678);

      // R5/R6: selector walk at index 0x20 (pc 0x80)
      resolve(32'h100, 6'd1, 8'd1, 8'h20, 1'b1, 1'b0, 1'b0);   // global right: 1->2
      fetch_check(32'h80);
      chk(fetch_use_global == 1'b1, "R5 step toward global", fetch_use_global, 1);
      resolve(32'h100, 6'd1, 8'd1, 8'h20, 1'b1, 1'b0, 1'b0);   // 2->3 strong
      resolve(32'h100, 6'd2, 8'd2, 8'h20, 1'b1, 1'b1, 1'b0);   // both wrong: hold
      resolve(32'h100, 6'd2, 8'd2, 8'h20, 1'b0, 1'b0, 1'b0);   // both right: hold
      resolve(32'h100, 6'd3, 8'd3, 8'h20, 1'b1, 1'b0, 1'b1);   // local right: 3->2
      fetch_check(32'h80);
      chk(fetch_use_global == 1'b1, "R6 one step from strong keeps selection", fetch_use_global, 1);
      resolve(32'h100, 6'd3, 8'd3, 8'h20, 1'b1, 1'b0, 1'b1);   // 2->1
      fetch_check(32'h80);
      chk(fetch_use_global == 1'b0, "R6 second step switches", fetch_use_global, 0);
      resolve(32'h100, 6'd3, 8'd3, 8'h20, 1'b1, 1'b0, 1'b1);   // 1->0
      resolve(32'h100, 6'd3, 8'd3, 8'h20, 1'b1, 1'b0, 1'b1);   // saturate at 0
      resolve(32'h100, 6'd3, 8'd3, 8'h20, 1'b0, 1'b1, 1'b1);   // 0->1
      fetch_check(32'h80);
      chk(fetch_use_global == 1'b0, "R6 floor saturation", fetch_use_global, 0);

      // R8: training follows the carried index, not rslv_pc
      resolve(32'h0000_0000, 6'd0, 8'h00, 8'h55, 1'b0, 1'b1, 1'b1);
      resolve(32'h0000_0000, 6'd0, 8'h00, 8'h55, 1'b0, 1'b1, 1'b1);
      fetch_check(32'h0000_0154);
      chk(fetch_use_global == 1'b1, "R8 carried selector index", fetch_use_global, 1);

      // R4/R3: a loop branch saturating, then one exit
      for (int i = 0; i < 12; i++) fetch_and_resolve(32'h0000_0A0C, 1'b1);
      fetch_and_resolve(32'h0000_0A0C, 1'b0);
      fetch_check(32'h0000_0A0C);

      // R9: junk on the resolve inputs with valid low changes nothing
      @(negedge clk);
      rslv_pc = 32'h0000_0A0C; rslv_local_idx = e_li; rslv_global_idx = e_gi;
      rslv_chooser_idx = e_ci; rslv_local_taken = 1'b1; rslv_global_taken = 1'b0; rslv_taken = 1'b0;
      rslv_valid = 1'b0;
      repeat (3) @(posedge clk);
      fetch_check(32'h0000_0A0C);
      fetch_check(32'h80);

      // random streams over a small PC pool with per-PC bias
      for (int i = 0; i < 16; i++) pool[i] = {$urandom(), 2'b00};
      for (int n = 0; n < 3000; n++) begin
         int unsigned k;
         logic t;
         k = $urandom_range(15);
         case (k % 4)
            0: t = 1'b1;
            1: t = 1'b0;
            2: t = ($urandom_range(9) < 8);
            default: t = m_gh[0] ^ m_gh[2];
         endcase
         fetch_and_resolve(pool[k], t);
      end

      // R1: reset again restores the initial state
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      model_reset();
      fetch_check(pool[0]);
      fetch_check(32'h80);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule